// File: doc/BRIEF.md
# SPI Multichannel ADC Scan Controller

This block is an SPI master for an external successive-approximation converter with four or eight inputs. A start strobe launches either a scan over every channel set in an enable mask or a direct read of one selected channel. Each channel takes two chip-select frames of 16 bits. The first frame writes a control word that selects the channel. The second frame, with all-zero MOSI, returns the conversion. Every returned word carries the channel address of the conversion. The block compares that address with the channel it asked for and reports either a valid result or a mismatch error.

The serial clock rate comes from a programmable divider. The controller holds `busy` while a scan runs and pulses `done` when it finishes. A start with nothing to convert completes at once and produces no bus activity. The power mode, range and coding fields of the control word are parameters. Their defaults are normal operation, range bit set and straight-binary coding.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset `cs_n` and `sclk` are 1 and `mosi`, `busy`, `done`, `res_valid` and `res_err` are 0.
- R2: A command frame, sent MSB first, is `{1, seq_hi=0, 0, ch[2:0], pm[1:0], seq_lo=0, 0, range, coding, 4'b0000}`, which is 16'h8330 | (ch << 10) with the default settings.
- R3: Each channel is served by a command frame followed by a separate read frame whose 16 MOSI bits are all 0, with `cs_n` returning high after every frame.
- R4: In scan mode one command/read pair is issued per set bit of `chan_mask`, in ascending channel order, and each result reports that channel on `res_ch`.
- R5: Bits 15:12 of a returned word are the channel address and bits 11:0 the data; on a match, `res_valid` pulses for one cycle with `res_data` equal to bits 11:0.
- R6: When bits 15:12 differ from the requested channel, `res_err` pulses instead of `res_valid`, and the two are never high together.
- R7: With `direct` high at start, exactly one channel, `direct_ch`, is converted and `chan_mask` is ignored.
- R8: A start while `busy` is high has no effect: it adds no frames, no results and no `done` pulse.
- R9: A scan start with an all-zero mask gives a `done` pulse in the next cycle, leaves `busy` low and causes no `cs_n` activity.
- R10: Each SCLK half period lasts `clk_div`+1 clock cycles, and `cs_n` stays high for at least two half periods between frames.
- R11: SCLK idles high; MOSI and MISO change on falling edges and are sampled on rising edges.
- R12: `busy` rises in the cycle after an accepted start. `done` pulses in the same cycle as the final result, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe for a scan or a direct read |
| direct | input | 1 | Selects single-channel direct read at start |
| direct_ch | input | CH_W | Channel for direct read |
| chan_mask | input | NUM_CH | Channel enable mask for scan mode |
| clk_div | input | DIV_W | SCLK half period minus one, in clock cycles |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | Result with matching channel address |
| res_err | output | 1 | Result whose channel address mismatched |
| res_ch | output | CH_W | Channel the result was requested for |
| res_data | output | 12 | Conversion data |

## Verification
The assertions assume that `clk_div` holds steady while `busy` is high, because the chip-select gap bound is measured against its present value. They also take `start` to be a one-cycle pulse whenever the mask is empty. The bench changes the divider only between scans and pulses every start for exactly one cycle. It repeats a start in the middle of a scan only to exercise the ignore rule. The converter model sends back a mismatched channel address only for channels the bench marks in advance.

// File: rtl/adc_scan_pkg.sv
// Package: shared constants, state types and the command-frame builder
// for the SPI ADC scan controller. Assumes a 16-bit frame whose control
// field occupies the upper 12 bits.
package adc_scan_pkg;

    localparam int FRAME_W = 16;
    localparam int CTRL_W  = 12;
    localparam int DATA_W  = 12;
    localparam int ID_W    = FRAME_W - DATA_W;
    localparam int PAD_W   = FRAME_W - CTRL_W;

    localparam logic [1:0] SEQ_NONE = 2'b00;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_CMD_WAIT,
        SQ_RD,
        SQ_RD_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_RUN,
        FR_GAP
    } frame_state_t;

    // Packs the control fields and left-aligns them in the frame.
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [2:0] ch,
        input logic [1:0] pm,
        input logic       rng,
        input logic       cod
    );
        logic [CTRL_W-1:0] w;
        w      = '0;
        w[11]  = 1'b1;
        w[10]  = SEQ_NONE[1];
        w[8:6] = ch;
        w[5:4] = pm;
        w[3]   = SEQ_NONE[0];
        w[1]   = rng;
        w[0]   = cod;
        return {w, {PAD_W{1'b0}}};
    endfunction

endpackage

// File: rtl/adc_tick_div.sv
// Tick divider: produces a one-cycle tick every clk_div+1 cycles while
// run is high. Assumes clk_div is steady during a frame.
module adc_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] clk_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == clk_div);

    // Counts cycles within one half period; cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == clk_div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_spi_frame.sv
// Frame engine: runs one chip-select frame of FRAME_W bits. SCLK idles
// high, MOSI is launched on falling edges, MISO is sampled on rising
// edges. After the frame, chip select stays high for two half periods
// before a new go is accepted. Assumes go is only raised while ready.
module adc_spi_frame
    import adc_scan_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic               go,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               ready,
    output logic               frame_done,
    output logic [FRAME_W-1:0] rx_word,
    input  logic               miso,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi
);
    localparam int LAST_EDGE = 2 * FRAME_W;
    localparam int EDGE_W    = $clog2(LAST_EDGE + 1);

    frame_state_t       state;
    logic [EDGE_W-1:0]  edge_cnt;
    logic [FRAME_W-1:0] tx_sh;
    logic [FRAME_W-1:0] rx_sh;
    logic               tick;

    assign ready   = (state == FR_IDLE);
    assign rx_word = rx_sh;

    adc_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state != FR_IDLE),
        .clk_div (clk_div),
        .tick    (tick)
    );

    // Frame sequencing: chip select, clock edges, shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= FR_IDLE;
            edge_cnt   <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            sclk       <= 1'b1;
            cs_n       <= 1'b1;
            mosi       <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (state)
                FR_IDLE: begin
                    if (go) begin
                        cs_n     <= 1'b0;
                        tx_sh    <= tx_word;
                        edge_cnt <= '0;
                        state    <= FR_RUN;
                    end
                end
                FR_RUN: begin
                    if (tick) begin
                        if (edge_cnt == EDGE_W'(LAST_EDGE)) begin
                            cs_n       <= 1'b1;
                            mosi       <= 1'b0;
                            frame_done <= 1'b1;
                            edge_cnt   <= '0;
                            state      <= FR_GAP;
                        end else begin
                            if (!edge_cnt[0]) begin
                                sclk  <= 1'b0;
                                mosi  <= tx_sh[FRAME_W-1];
                                tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                            end else begin
                                sclk  <= 1'b1;
                                rx_sh <= {rx_sh[FRAME_W-2:0], miso};
                            end
                            edge_cnt <= edge_cnt + 1'b1;
                        end
                    end
                end
                FR_GAP: begin
                    if (tick) begin
                        if (edge_cnt[0]) begin
                            state <= FR_IDLE;
                        end
                        edge_cnt <= edge_cnt + 1'b1;
                    end
                end
                default: state <= FR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
// Scan sequencer: latches the channel set at start, then for the lowest
// pending channel issues a command frame and a read frame, retiring the
// channel when the read completes. Starts are ignored while busy.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int         NUM_CH     = 8,
    parameter logic [1:0] PM_MODE    = 2'b11,
    parameter logic       RANGE_BIT  = 1'b1,
    parameter logic       CODING_BIT = 1'b1,
    localparam int        CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               direct,
    input  logic [CH_W-1:0]    direct_ch,
    input  logic [NUM_CH-1:0]  chan_mask,
    input  logic               ready,
    input  logic               frame_done,
    output logic               go,
    output logic [FRAME_W-1:0] tx_word,
    output logic [CH_W-1:0]    cur_ch,
    output logic               capture,
    output logic               busy,
    output logic               done
);
    seq_state_t        state;
    logic [NUM_CH-1:0] pending;
    logic [NUM_CH-1:0] start_set;
    logic [NUM_CH-1:0] remain;

    // Channel set chosen at start: one bit for direct, else the mask.
    always_comb begin
        if (direct) begin
            start_set = NUM_CH'(1) << direct_ch;
        end else begin
            start_set = chan_mask;
        end
    end

    // Lowest pending channel gives ascending service order.
    always_comb begin
        cur_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pending[i]) begin
                cur_ch = CH_W'(i);
            end
        end
    end

    assign remain  = pending & ~(NUM_CH'(1) << cur_ch);
    assign go      = ready && ((state == SQ_CMD) || (state == SQ_RD));
    assign capture = (state == SQ_RD_WAIT) && frame_done;
    assign tx_word = (state == SQ_CMD) ?
                     build_frame(3'(cur_ch), PM_MODE, RANGE_BIT, CODING_BIT) :
                     '0;

    // Scan control: start acceptance, frame pairing, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            pending <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        if (|start_set) begin
                            pending <= start_set;
                            busy    <= 1'b1;
                            state   <= SQ_CMD;
                        end else begin
                            done <= 1'b1;
                        end
                    end
                end
                SQ_CMD: begin
                    if (ready) state <= SQ_CMD_WAIT;
                end
                SQ_CMD_WAIT: begin
                    if (frame_done) state <= SQ_RD;
                end
                SQ_RD: begin
                    if (ready) state <= SQ_RD_WAIT;
                end
                SQ_RD_WAIT: begin
                    if (frame_done) begin
                        pending <= remain;
                        if (remain == '0) begin
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            state <= SQ_IDLE;
                        end else begin
                            state <= SQ_CMD;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_result_check.sv
// Result checker: on capture, compares the returned channel address with
// the requested channel and registers either a valid result or an error.
module adc_result_check
    import adc_scan_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [CH_W-1:0]    exp_ch,
    input  logic [FRAME_W-1:0] rx_word,
    output logic               res_valid,
    output logic               res_err,
    output logic [CH_W-1:0]    res_ch,
    output logic [DATA_W-1:0]  res_data
);
    logic id_match;

    assign id_match = (rx_word[FRAME_W-1:DATA_W] == ID_W'(exp_ch));

    // Registers the result and its match status for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_err   <= 1'b0;
            res_ch    <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            res_err   <= 1'b0;
            if (capture) begin
                res_ch    <= exp_ch;
                res_data  <= rx_word[DATA_W-1:0];
                res_valid <= id_match;
                res_err   <= !id_match;
            end
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
// Top: SPI master scan controller for a multichannel SAR ADC. Joins the
// sequencer, the frame engine and the result checker. Assumes clk_div is
// held while busy and that the converter answers in the frame after the
// command.
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int         NUM_CH     = 8,
    parameter int         DIV_W      = 8,
    parameter logic [1:0] PM_MODE    = 2'b11,
    parameter logic       RANGE_BIT  = 1'b1,
    parameter logic       CODING_BIT = 1'b1,
    localparam int        CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              direct,
    input  logic [CH_W-1:0]   direct_ch,
    input  logic [NUM_CH-1:0] chan_mask,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              miso,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic              res_valid,
    output logic              res_err,
    output logic [CH_W-1:0]   res_ch,
    output logic [11:0]       res_data
);
    logic               go;
    logic               ready;
    logic               frame_done;
    logic               capture;
    logic [FRAME_W-1:0] tx_word;
    logic [FRAME_W-1:0] rx_word;
    logic [CH_W-1:0]    cur_ch;

    adc_scan_seq #(
        .NUM_CH     (NUM_CH),
        .PM_MODE    (PM_MODE),
        .RANGE_BIT  (RANGE_BIT),
        .CODING_BIT (CODING_BIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .direct     (direct),
        .direct_ch  (direct_ch),
        .chan_mask  (chan_mask),
        .ready      (ready),
        .frame_done (frame_done),
        .go         (go),
        .tx_word    (tx_word),
        .cur_ch     (cur_ch),
        .capture    (capture),
        .busy       (busy),
        .done       (done)
    );

    adc_spi_frame #(.DIV_W(DIV_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_div    (clk_div),
        .go         (go),
        .tx_word    (tx_word),
        .ready      (ready),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .miso       (miso),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi)
    );

    adc_result_check #(.CH_W(CH_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .exp_ch    (cur_ch),
        .rx_word   (rx_word),
        .res_valid (res_valid),
        .res_err   (res_err),
        .res_ch    (res_ch),
        .res_data  (res_data)
    );
endmodule

// File: rtl/adc_scan_checker.sv
// Checker: protocol and handshake properties of adc_scan_ctrl, attached
// by bind. Assumes clk_div steady while busy and one-cycle start pulses.
module adc_scan_checker #(
    parameter int NUM_CH = 8,
    parameter int DIV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              direct,
    input logic [NUM_CH-1:0] chan_mask,
    input logic [DIV_W-1:0]  clk_div,
    input logic              sclk,
    input logic              cs_n,
    input logic              mosi,
    input logic              busy,
    input logic              done,
    input logic              res_valid,
    input logic              res_err
);
    localparam int GAP_W = DIV_W + 2;

    logic [GAP_W-1:0] gap_cnt;
    logic [GAP_W-1:0] gap_need;

    assign gap_need = ({2'b00, clk_div} + 1'b1) << 1;

    // Counts cycles with chip select high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '1;
        end else if (!cs_n) begin
            gap_cnt <= '0;
        end else if (gap_cnt != '1) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (gap_cnt >= gap_need));

    a_r11_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    a_r11_mosi_held_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && sclk && $past(sclk)) |-> $stable(mosi));

    a_r6_result_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_err));

    a_r12_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (direct || (|chan_mask))) |=> busy);

    a_r9_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !direct && (chan_mask == '0)) |=> (done && !busy));

    a_r12_result_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || res_err) |-> $past(busy));
endmodule

bind adc_scan_ctrl adc_scan_checker #(
    .NUM_CH (NUM_CH),
    .DIV_W  (DIV_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .direct    (direct),
    .chan_mask (chan_mask),
    .clk_div   (clk_div),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .busy      (busy),
    .done      (done),
    .res_valid (res_valid),
    .res_err   (res_err)
);

// File: tb/tb_adc_scan_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task queues expected command frames and
// results; a converter model and a result monitor pop and compare them.
module tb_adc_scan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        direct = 1'b0;
    logic [2:0]  direct_ch = '0;
    logic [7:0]  chan_mask = '0;
    logic [7:0]  clk_div = 8'd1;
    logic        miso = 1'b0;
    logic        sclk, cs_n, mosi, busy, done, res_valid, res_err;
    logic [2:0]  res_ch;
    logic [11:0] res_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int div_now = 1;
    int cs_falls = 0;
    int done_cnt = 0;

    logic [15:0] exp_cmd[$];
    logic [15:0] exp_res[$];
    logic [11:0] data_tbl[8];
    logic        bad_id[8];

    always #2 clk = ~clk;

    adc_scan_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .direct(direct),
        .direct_ch(direct_ch), .chan_mask(chan_mask), .clk_div(clk_div),
        .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy),
        .done(done), .res_valid(res_valid), .res_err(res_err),
        .res_ch(res_ch), .res_data(res_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Converter model state
    logic [15:0] s_resp, s_rx;
    logic [3:0]  s_id;
    logic [2:0]  s_last = '0;
    int          s_k = 0;
    bit          s_in = 0;
    bit          s_want_read = 0;
    bit          s_have_rise = 0;
    realtime     t_rise = 0, t_fall = 0;

    always @(negedge cs_n) begin
        s_in = 1;
        s_k = 0;
        s_rx = '0;
        cs_falls++;
        s_id = bad_id[s_last] ? ({1'b0, s_last} + 4'd1) : {1'b0, s_last};
        s_resp = {s_id, data_tbl[s_last]};
        if (s_have_rise)
            chk(($realtime - t_rise) >= 2.0 * (div_now + 1) * 4.0, "R10",
                "cs_n high gap ns", int'($realtime - t_rise), 2 * (div_now + 1) * 4);
    end

    always @(negedge sclk) begin
        if (s_in && !cs_n && s_k < 16) begin
            miso <= s_resp[15 - s_k];
            s_k++;
            t_fall = $realtime;
        end
    end

    always @(posedge sclk) begin
        if (s_in && !cs_n) begin
            s_rx = {s_rx[14:0], mosi};
            if (s_k == 1)
                chk(($realtime - t_fall) == (div_now + 1) * 4.0, "R10",
                    "sclk low half period ns", int'($realtime - t_fall), (div_now + 1) * 4);
        end
    end

    always @(posedge cs_n) begin
        if (s_in) begin
            s_in = 0;
            t_rise = $realtime;
            s_have_rise = 1;
            if (s_want_read) begin
                chk(s_rx == 16'h0000, "R3", "read frame mosi", s_rx, 0);
                s_want_read = 0;
            end else if (exp_cmd.size() == 0) begin
                chk(0, "R4", "unexpected command frame", s_rx, 0);
                s_want_read = 1;
            end else begin
                logic [15:0] e;
                e = exp_cmd.pop_front();
                chk(s_rx == e, "R2", "command frame (R4 order)", s_rx, e);
                s_last = s_rx[12:10];
                s_want_read = 1;
            end
        end
    end

    // Result monitor
    always @(negedge clk) begin
        if (rst_n && done) done_cnt++;
        if (rst_n && (res_valid || res_err)) begin
            chk(!(res_valid && res_err), "R6", "valid and err together", 1, 0);
            if (exp_res.size() == 0) begin
                chk(0, "R5", "unexpected result", res_ch, 0);
            end else begin
                logic [15:0] e;
                e = exp_res.pop_front();
                chk(res_ch == e[14:12], "R4", "result channel", res_ch, e[14:12]);
                chk(res_err == e[15], "R6", "mismatch flag", res_err, e[15]);
                if (!e[15])
                    chk(res_data == e[11:0], "R5", "result data", res_data, e[11:0]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic run_scan(input logic [7:0] mask, input bit dmode,
                            input logic [2:0] dch, input int div, input bit poke);
        logic [7:0] m;
        int cf, dc;
        div_now = div;
        clk_div = 8'(div);
        m = dmode ? (8'b1 << dch) : mask;
        for (int ch = 0; ch < 8; ch++) begin
            if (m[ch]) begin
                exp_cmd.push_back(16'h8330 | (16'(ch) << 10));
                exp_res.push_back({bad_id[ch], 3'(ch), data_tbl[ch]});
            end
        end
        dc = done_cnt;
        @(negedge clk);
        chan_mask = mask;
        direct = dmode;
        direct_ch = dch;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (m == 8'h00) begin
            chk(done && !busy, "R9", "done at once, busy low", {done, busy}, 2'b10);
            cf = cs_falls;
            repeat (40) @(negedge clk);
            chk(cs_falls == cf, "R9", "no frame for empty mask", cs_falls, cf);
            return;
        end
        chk(busy == 1'b1, "R12", "busy after start", busy, 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            chan_mask = 8'hFF;
            direct = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(!busy, "R12", "busy low at done", busy, 0);
        chk(res_valid || res_err, "R12", "last result with done", res_valid | res_err, 1);
        cf = cs_falls;
        repeat (100) @(negedge clk);
        chk(cs_falls == cf, "R8", "no frames after done", cs_falls, cf);
        chk(done_cnt == dc + 1, "R8", "single done pulse", done_cnt, dc + 1);
        chk(exp_cmd.size() == 0, "R4", "commands left", exp_cmd.size(), 0);
        chk(exp_res.size() == 0, "R4", "results left", exp_res.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            data_tbl[i] = 12'(i * 337 + 91);
            bad_id[i] = 1'b0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && sclk && !mosi, "R1", "bus lines after reset", {cs_n, sclk, mosi}, 3'b110);
        chk(!busy && !done && !res_valid && !res_err, "R1", "status after reset",
            {busy, done, res_valid, res_err}, 0);

        run_scan(8'b1010_0101, 1'b0, 3'd0, 1, 1'b0);   // R4 sparse ascending
        run_scan(8'hFF, 1'b0, 3'd0, 0, 1'b0);          // R4, R11 fastest clock
        run_scan(8'h0F, 1'b1, 3'd5, 2, 1'b0);          // R7 mask ignored
        bad_id[3] = 1'b1;
        run_scan(8'b0000_1110, 1'b0, 3'd0, 1, 1'b0);   // R6 mismatch on ch 3
        bad_id[3] = 1'b0;
        run_scan(8'h03, 1'b0, 3'd0, 1, 1'b1);          // R8 start while busy
        run_scan(8'h00, 1'b0, 3'd0, 1, 1'b0);          // R9 empty mask
        run_scan(8'hF0, 1'b1, 3'd0, 3, 1'b0);          // R7 direct ch 0
        run_scan(8'h80, 1'b0, 3'd0, 1, 1'b0);          // R5 top channel only

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule